// File: doc/BRIEF.md
# Privileged Register Access Gate

This block judges decoded register-access instructions, one at a time, against the privilege level they run at. Each request carries an access-class code that names the kind of register the instruction touches. The gate answers one clock later with exactly one of two flags: the access may run, or it must raise a general-protection fault. Instruction decode, the register file and fault delivery all sit outside the block. It only classifies.

The rules are applied per register class and are not a single supervisor-only test. The ordinary computational registers are open at every level. Model-specific, control, debug, descriptor-table and task registers are closed to any level above the most privileged. Two classes are exceptions. The performance-counter read depends on an enable set by the supervisor. The machine-status-word store depends on a user-instruction-prevention bit, and a build parameter selects a processor flavour that has no such bit, in which case the store is always open.

Top module: `priv_access_gate`

## Requirements
- R1: `resValid` is high exactly one cycle after a cycle with `reqValid` high, and low otherwise. During reset `resValid`, `resAllow` and `resFault` are all 0.
- R2: `resAllow` and `resFault` are never high together. While `resValid` is high exactly one of them is high. While `resValid` is low both are 0.
- R3: Class code 0 (computational registers: general-purpose, floating-point/MMX, vector and mask) is allowed at every privilege level.
- R4: At privilege 0, every defined class (codes 0 to 8) is allowed, whatever the values of `preventBit` and `cntEnable`.
- R5: At privilege 1, 2 or 3, class codes 1 (model-specific register read) and 2 (model-specific register write) fault.
- R6: At privilege 1, 2 or 3, class codes 3 (control register, any index 0 to 15) and 4 (debug register, any index 0 to 15) fault.
- R7: At privilege 1, 2 or 3, class codes 5 (global, interrupt or local descriptor-table register) and 6 (task register) fault.
- R8: At privilege 1, 2 or 3, class code 7 (performance-counter read) is allowed when `cntEnable` is 1 and faults when it is 0.
- R9: With `HAS_PREVENT` = 1, class code 8 (machine-status-word store) at privilege 1, 2 or 3 is allowed when `preventBit` is 0 and faults when it is 1.
- R10: With `HAS_PREVENT` = 0, class code 8 is allowed at every privilege level and `preventBit` has no effect.
- R11: Class codes 9 to 15 are undefined and fault at every privilege level, including 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| accessClass | input | 4 | Access-class code of the request |
| cpl | input | 2 | Current privilege level, 0 is the most privileged |
| preventBit | input | 1 | User-instruction-prevention bit |
| cntEnable | input | 1 | Supervisor enable for the counter read at privilege above 0 |
| resValid | output | 1 | Verdict is valid |
| resAllow | output | 1 | Access may run |
| resFault | output | 1 | Access must raise a general-protection fault |

## Verification
The bench sweeps every class code against every privilege level. A gate that tests only "privilege above 0" would then fault the computational class in user mode or leak a closed class. The two exception classes are driven with their control bits in both states. A design that ignored the counter enable, or inverted the sense of the prevention bit, would flip verdicts at privilege 1 to 3 while looking correct at privilege 0. A second instance built without the prevention bit must keep the status-word store open even with the bit set. Undefined codes are sent at privilege 0, where a design that lets privilege 0 override all rules would wrongly allow them. Gap cycles between requests confirm that no stale verdict stays on the outputs.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;

  localparam int CLASS_W = 4;
  localparam int CPL_W   = 2;

  // access-class codes seen on the request port
  localparam logic [CLASS_W-1:0] AC_COMPUTE   = 4'd0;
  localparam logic [CLASS_W-1:0] AC_MODEL_RD  = 4'd1;
  localparam logic [CLASS_W-1:0] AC_MODEL_WR  = 4'd2;
  localparam logic [CLASS_W-1:0] AC_CTRL      = 4'd3;
  localparam logic [CLASS_W-1:0] AC_DEBUG     = 4'd4;
  localparam logic [CLASS_W-1:0] AC_DESC_TBL  = 4'd5;
  localparam logic [CLASS_W-1:0] AC_TASK      = 4'd6;
  localparam logic [CLASS_W-1:0] AC_CNT_RD    = 4'd7;
  localparam logic [CLASS_W-1:0] AC_STATUS_ST = 4'd8;
  localparam logic [CLASS_W-1:0] AC_LAST_DEF  = AC_STATUS_ST;

  // how a class is judged
  typedef enum logic [2:0] {
    RULE_OPEN,     // allowed everywhere
    RULE_KERNEL,   // allowed only at level 0
    RULE_COUNTER,  // level 0, or counter enable set
    RULE_STATUS,   // level 0, or prevention bit clear (or absent)
    RULE_BAD       // undefined code, always faults
  } gateRule_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // a verdict is to be registered
    logic grant;    // verdict is allow (else fault)
  } gateStrobes_t;

endpackage

// File: rtl/priv_gate_ctrl.sv
module priv_gate_ctrl
  import priv_gate_pkg::*;
#(
  parameter bit HAS_PREVENT = 1'b1
) (
  input  logic               reqValid,
  input  logic [CLASS_W-1:0] accessClass,
  input  logic [CPL_W-1:0]   cpl,
  input  logic               preventBit,
  input  logic               cntEnable,
  output gateStrobes_t       strobes
);

  gateRule_t rule;
  logic      isRing0;
  logic      statusOpen;
  logic      grantNow;

  // class code to rule kind
  always_comb begin
    unique case (accessClass)
      AC_COMPUTE:   rule = RULE_OPEN;
      AC_MODEL_RD,
      AC_MODEL_WR,
      AC_CTRL,
      AC_DEBUG,
      AC_DESC_TBL,
      AC_TASK:      rule = RULE_KERNEL;
      AC_CNT_RD:    rule = RULE_COUNTER;
      AC_STATUS_ST: rule = RULE_STATUS;
      default:      rule = RULE_BAD;
    endcase
  end

  assign isRing0 = (cpl == '0);

  // flavour without a prevention bit keeps the status store open
  generate
    if (HAS_PREVENT) begin : g_prevent
      assign statusOpen = ~preventBit;
    end else begin : g_noPrevent
      logic unusedPrevent;
      assign unusedPrevent = preventBit;
      assign statusOpen    = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (rule)
      RULE_OPEN:    grantNow = 1'b1;
      RULE_KERNEL:  grantNow = isRing0;
      RULE_COUNTER: grantNow = isRing0 | cntEnable;
      RULE_STATUS:  grantNow = isRing0 | statusOpen;
      default:      grantNow = 1'b0;
    endcase
  end

  assign strobes.capture = reqValid;
  assign strobes.grant   = grantNow;

endmodule

// File: rtl/priv_gate_dp.sv
module priv_gate_dp
  import priv_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  gateStrobes_t strobes,
  output logic         resValid,
  output logic         resAllow,
  output logic         resFault
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resAllow <= 1'b0;
      resFault <= 1'b0;
    end else begin
      resValid <= strobes.capture;
      resAllow <= strobes.capture &  strobes.grant;
      resFault <= strobes.capture & ~strobes.grant;
    end
  end

endmodule

// File: rtl/priv_access_gate.sv
module priv_access_gate
  import priv_gate_pkg::*;
#(
  parameter bit HAS_PREVENT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CLASS_W-1:0] accessClass,
  input  logic [CPL_W-1:0]   cpl,
  input  logic               preventBit,
  input  logic               cntEnable,
  output logic               resValid,
  output logic               resAllow,
  output logic               resFault
);

  gateStrobes_t strobes;

  priv_gate_ctrl #(.HAS_PREVENT(HAS_PREVENT)) u_ctrl (
    .reqValid    (reqValid),
    .accessClass (accessClass),
    .cpl         (cpl),
    .preventBit  (preventBit),
    .cntEnable   (cntEnable),
    .strobes     (strobes)
  );

  priv_gate_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .resValid (resValid),
    .resAllow (resAllow),
    .resFault (resFault)
  );

endmodule

// File: rtl/priv_gate_chk.sv
module priv_gate_chk
  import priv_gate_pkg::*;
#(
  parameter bit HAS_PREVENT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [CLASS_W-1:0] accessClass,
  input logic [CPL_W-1:0]   cpl,
  input logic               preventBit,
  input logic               cntEnable,
  input logic               resValid,
  input logic               resAllow,
  input logic               resFault
);

  logic seenEdge;
  always_ff @(posedge clk) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(resAllow && resFault));
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rstN || !seenEdge)
    resValid |-> $onehot({resAllow, resFault}));
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN || !seenEdge)
    !resValid |-> !resAllow && !resFault);
  p_compute_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accessClass == AC_COMPUTE) |=> resAllow);
  p_ring0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cpl == '0 && accessClass <= AC_LAST_DEF) |=> resAllow);
  p_kernel_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cpl != '0 && accessClass >= AC_MODEL_RD && accessClass <= AC_TASK)
      |=> resFault);
  p_counter_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cpl != '0 && accessClass == AC_CNT_RD) |=> (resAllow == $past(cntEnable)));
  p_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cpl != '0 && accessClass == AC_STATUS_ST)
      |=> (resFault == (HAS_PREVENT && $past(preventBit))));
  p_undefined_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accessClass > AC_LAST_DEF) |=> resFault);

endmodule

bind priv_access_gate priv_gate_chk #(.HAS_PREVENT(HAS_PREVENT)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .accessClass (accessClass),
  .cpl         (cpl),
  .preventBit  (preventBit),
  .cntEnable   (cntEnable),
  .resValid    (resValid),
  .resAllow    (resAllow),
  .resFault    (resFault)
);

// File: tb/priv_access_gate_tb.sv
`timescale 1ns/1ps
module priv_access_gate_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic [3:0] accessClass;
  logic [1:0] cpl;
  logic       preventBit;
  logic       cntEnable;
  logic       vA, aA, fA;   // prevention-bit flavour
  logic       vB, aB, fB;   // flavour without the bit

  int compared   = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  priv_access_gate #(.HAS_PREVENT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accessClass(accessClass),
    .cpl(cpl), .preventBit(preventBit), .cntEnable(cntEnable),
    .resValid(vA), .resAllow(aA), .resFault(fA));

  priv_access_gate #(.HAS_PREVENT(1'b0)) u_dut_noprev (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accessClass(accessClass),
    .cpl(cpl), .preventBit(preventBit), .cntEnable(cntEnable),
    .resValid(vB), .resAllow(aB), .resFault(fB));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {valid,allow,fault} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // expected allow bit from the requirement list
  function automatic logic expAllow(input logic [3:0] c, input logic [1:0] l,
                                    input logic pb, input logic ce, input logic hasPb);
    if (c > 4'd8) return 1'b0;                       // R11
    if (c == 4'd0) return 1'b1;                      // R3
    if (l == 2'd0) return 1'b1;                      // R4
    if (c == 4'd7) return ce;                        // R8
    if (c == 4'd8) return hasPb ? !pb : 1'b1;        // R9, R10
    return 1'b0;                                     // R5, R6, R7
  endfunction

  // one request, verdict checked one cycle later on both flavours
  task automatic send(input string req, input logic [3:0] c, input logic [1:0] l,
                      input logic pb, input logic ce);
    logic ea, eb;
    @(negedge clk);
    reqValid = 1'b1; accessClass = c; cpl = l; preventBit = pb; cntEnable = ce;
    @(negedge clk);
    reqValid = 1'b0;
    ea = expAllow(c, l, pb, ce, 1'b1);
    eb = expAllow(c, l, pb, ce, 1'b0);
    check(req, {vA, aA, fA}, {1'b1, ea, !ea});
    check(req, {vB, aB, fB}, {1'b1, eb, !eb});
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check(req, {vA, aA, fA}, 3'b000);
    check(req, {vB, aB, fB}, 3'b000);
  endtask

  task automatic t_reset_r1;
    rstN = 1'b0; reqValid = 1'b1; accessClass = 4'd0; cpl = 2'd0;
    preventBit = 1'b0; cntEnable = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", {vA, aA, fA}, 3'b000);
    check("R1 reset", {vB, aB, fB}, 3'b000);
    reqValid = 1'b0; rstN = 1'b1;
    idle_check("R1 idle after reset");
  endtask

  task automatic t_compute_r3;
    for (int l = 0; l < 4; l++) send("R3 compute", 4'd0, 2'(l), 1'b1, 1'b0);
  endtask

  task automatic t_ring0_r4;
    for (int c = 0; c < 9; c++) send("R4 ring0", 4'(c), 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_kernel_r5_r6_r7;
    for (int c = 1; c < 7; c++)
      for (int l = 1; l < 4; l++)
        send(c < 3 ? "R5 model reg" : (c < 5 ? "R6 ctrl/debug" : "R7 table/task"),
             4'(c), 2'(l), 1'b0, 1'b1);
  endtask

  task automatic t_counter_r8;
    for (int l = 1; l < 4; l++) begin
      send("R8 counter enabled", 4'd7, 2'(l), 1'b0, 1'b1);
      send("R8 counter disabled", 4'd7, 2'(l), 1'b0, 1'b0);
    end
  endtask

  task automatic t_status_r9_r10;
    for (int l = 0; l < 4; l++) begin
      send("R9 R10 status store prevent=1", 4'd8, 2'(l), 1'b1, 1'b0);
      send("R9 R10 status store prevent=0", 4'd8, 2'(l), 1'b0, 1'b0);
    end
  endtask

  task automatic t_undefined_r11;
    for (int c = 9; c < 16; c++) begin
      send("R11 undefined ring0", 4'(c), 2'd0, 1'b0, 1'b1);
      send("R11 undefined ring3", 4'(c), 2'd3, 1'b0, 1'b1);
    end
  endtask

  task automatic t_gap_r2;
    send("R2 before gap", 4'd0, 2'd3, 1'b0, 1'b0);
    idle_check("R2 gap clears verdict");
    send("R2 before gap", 4'd3, 2'd3, 1'b0, 1'b0);
    idle_check("R2 gap clears verdict");
  endtask

  initial begin
    fork
      begin
        t_reset_r1();
        t_compute_r3();
        t_ring0_r4();
        t_kernel_r5_r6_r7();
        t_counter_r8();
        t_status_r9_r10();
        t_undefined_r11();
        t_gap_r2();
      end
      begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule